// File: doc/BRIEF.md
# Batched Host Interrupt Controller

This block gathers event pulses from one transmit DMA channel and one receive DMA channel and raises a single active-high interrupt to the host. Each event source passes through an enable bit held in one of two 16-bit enable registers. A qualified event that arrives while no interrupt is outstanding becomes part of the *pending* batch, and the interrupt output rises.

While a batch is pending, later qualified events do not join it. They collect in a separate *held* set. The host acknowledges by writing ones to the status registers, which clears only the matching pending bits. When the pending batch becomes empty, the held set is promoted to the new pending batch one cycle later. The interrupt therefore drops for one cycle and rises again for the events that arrived late. The pending batch can be seen both through the status registers and through a dedicated status port.

Top module: `irq_batch_ctrl`

## Requirements
- R1: Enable register A (address 0x58) stores only bit 11 (transmit table done/hold), bit 8 (receive table full/hold) and bit 2 (receive block done). Enable register B (address 0x59) stores only bit 5 (transmit underrun) and bit 2 (receive overrun). All other bits read as zero whatever was written.
- R2: A synchronous reset clears both enable registers, the pending batch and the held set. Without a write, the enable registers keep their value.
- R3: An event whose enable bit is clear is neither put in the pending batch nor held, so the interrupt stays low for it.
- R4: While the pending batch is non-empty, a new qualified event goes to the held set. The pending batch and the status registers do not change.
- R5: Writing ones to status register A (0x5A, same bit layout as enable A) or status register B (0x5B, same bit layout as enable B) clears only the pending bits written as one. The held set is not affected.
- R6: When an acknowledge empties the pending batch and the held set is non-empty, the interrupt output is low in the next cycle and high in the cycle after that. The former held set is then the pending batch.
- R7: One cycle after a qualified event with nothing outstanding, the interrupt output goes high. It stays high while the pending batch is non-empty and is low when both sets are empty.
- R8: On each descriptor-table channel, the done pulse and the hold pulse each set the same event bit.
- R9: The status port shows the pending batch in this order: bit 0 transmit table, bit 1 receive table, bit 2 receive block done, bit 3 transmit underrun, bit 4 receive overrun.
- R10: An event in the same cycle as the acknowledge that empties the batch is held and raises the next interrupt. It is not lost.
- R11: Repeated pulses of the same event while it is held collapse into one held bit, which one acknowledge clears.
- R12: Reads of any address other than the four registers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational from reg_addr) |
| ev_tx_dt_done | input | 1 | Transmit descriptor table used up |
| ev_tx_hold | input | 1 | Transmit channel hold condition |
| ev_rx_dt_full | input | 1 | Receive descriptor table full |
| ev_rx_hold | input | 1 | Receive channel hold condition |
| ev_rx_blk_done | input | 1 | Receive block done, already qualified by status write-back |
| ev_tx_underrun | input | 1 | Transmit buffer fetch request not serviced |
| ev_rx_overrun | input | 1 | Receive overrun |
| irq_o | output | 1 | Host interrupt, active high |
| stat_pend_o | output | 5 | Pending batch status port |

## Verification
The hardest situation to reach is an event that lands in the exact cycle of the acknowledge that empties the pending batch. This must give the one-cycle dip and then a second interrupt that carries only that event. The stimulus drives the acknowledge write and the event pulse on the same clock. It does the same with a full held set, with a partial acknowledge, and with repeated pulses. A behavioural reference model checks the interrupt and the status port on every clock.

// File: rtl/irq_batch_pkg.sv
package irq_batch_pkg;
   localparam int NUM_EVT   = 5;
   localparam int EV_TX_DT  = 0;
   localparam int EV_RX_DT  = 1;
   localparam int EV_RX_BLK = 2;
   localparam int EV_TX_UR  = 3;
   localparam int EV_RX_OV  = 4;

   localparam int BIT_TX_DT  = 11;
   localparam int BIT_RX_DT  = 8;
   localparam int BIT_RX_BLK = 2;
   localparam int BIT_TX_UR  = 5;
   localparam int BIT_RX_OV  = 2;

   typedef logic [NUM_EVT-1:0] evt_vec_t;

   function automatic logic [15:0] word_a(evt_vec_t v);
      logic [15:0] w;
      w = '0;
      w[BIT_TX_DT]  = v[EV_TX_DT];
      w[BIT_RX_DT]  = v[EV_RX_DT];
      w[BIT_RX_BLK] = v[EV_RX_BLK];
      return w;
   endfunction

   function automatic logic [15:0] word_b(evt_vec_t v);
      logic [15:0] w;
      w = '0;
      w[BIT_TX_UR] = v[EV_TX_UR];
      w[BIT_RX_OV] = v[EV_RX_OV];
      return w;
   endfunction

   function automatic evt_vec_t vec_a(logic [15:0] w);
      evt_vec_t v;
      v = '0;
      v[EV_TX_DT]  = w[BIT_TX_DT];
      v[EV_RX_DT]  = w[BIT_RX_DT];
      v[EV_RX_BLK] = w[BIT_RX_BLK];
      return v;
   endfunction

   function automatic evt_vec_t vec_b(logic [15:0] w);
      evt_vec_t v;
      v = '0;
      v[EV_TX_UR] = w[BIT_TX_UR];
      v[EV_RX_OV] = w[BIT_RX_OV];
      return v;
   endfunction
endpackage

// File: rtl/irq_en_regs.sv
module irq_en_regs
   import irq_batch_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] EN_A_ADDR = 8'h58,
   parameter logic [ADDR_W-1:0] EN_B_ADDR = 8'h59
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       wdata,
   output evt_vec_t          en_vec
);
   localparam evt_vec_t MASK_A = vec_a(16'hFFFF);
   localparam evt_vec_t MASK_B = vec_b(16'hFFFF);

   evt_vec_t en_q;
   logic     hit_a, hit_b;

   assign hit_a = wr && (addr == EN_A_ADDR);
   assign hit_b = wr && (addr == EN_B_ADDR);

   always_ff @(posedge clk) begin
      if (srst) begin
         en_q <= '0;
      end else begin
         if (hit_a) en_q <= (en_q & ~MASK_A) | vec_a(wdata);
         if (hit_b) en_q <= (en_q & ~MASK_B) | vec_b(wdata);
      end
   end

   assign en_vec = en_q;

   AST_EN_HOLDS: assert property (@(posedge clk) disable iff (srst)
      !(hit_a || hit_b) |=> $stable(en_q));  // R2
endmodule

// File: rtl/irq_evt_cell.sv
module irq_evt_cell (
   input  logic clk,
   input  logic srst,
   input  logic evt,
   input  logic ack,
   input  logic busy,
   output logic pend,
   output logic held
);
   logic pend_q, held_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         pend_q <= 1'b0;
         held_q <= 1'b0;
      end else if (!busy) begin
         pend_q <= held_q | evt;
         held_q <= 1'b0;
      end else begin
         pend_q <= pend_q & ~ack;
         held_q <= held_q | evt;
      end
   end

   assign pend = pend_q;
   assign held = held_q;

   AST_LATE_EVENT_HELD: assert property (@(posedge clk) disable iff (srst)
      (busy && evt) |=> held_q);  // R4
   AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (srst)
      (busy && ack) |=> !pend_q);  // R5
endmodule

// File: rtl/irq_batch_ctrl.sv
module irq_batch_ctrl
   import irq_batch_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] EN_A_ADDR = 8'h58,
   parameter logic [ADDR_W-1:0] EN_B_ADDR = 8'h59,
   parameter logic [ADDR_W-1:0] ST_A_ADDR = 8'h5A,
   parameter logic [ADDR_W-1:0] ST_B_ADDR = 8'h5B
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ev_tx_dt_done,
   input  logic              ev_tx_hold,
   input  logic              ev_rx_dt_full,
   input  logic              ev_rx_hold,
   input  logic              ev_rx_blk_done,
   input  logic              ev_tx_underrun,
   input  logic              ev_rx_overrun,
   output logic              irq_o,
   output logic [NUM_EVT-1:0] stat_pend_o
);
   initial begin
      assert (DATA_W == 16) else $error("DATA_W must be 16");
      assert (ADDR_W >= 7) else $error("ADDR_W too narrow for register map");
   end

   evt_vec_t en_vec, raw_evt, evt_q, ack_vec, pend_vec, held_vec;
   logic     busy;
   logic [15:0] wd16;

   assign wd16 = reg_wdata[15:0];

   irq_en_regs #(.ADDR_W(ADDR_W), .EN_A_ADDR(EN_A_ADDR), .EN_B_ADDR(EN_B_ADDR)) u_en (
      .clk(clk), .srst(srst), .wr(reg_wr), .addr(reg_addr), .wdata(wd16), .en_vec(en_vec));

   always_comb begin
      raw_evt = '0;
      raw_evt[EV_TX_DT]  = ev_tx_dt_done | ev_tx_hold;
      raw_evt[EV_RX_DT]  = ev_rx_dt_full | ev_rx_hold;
      raw_evt[EV_RX_BLK] = ev_rx_blk_done;
      raw_evt[EV_TX_UR]  = ev_tx_underrun;
      raw_evt[EV_RX_OV]  = ev_rx_overrun;
   end

   assign evt_q = raw_evt & en_vec;

   always_comb begin
      ack_vec = '0;
      if (reg_wr && reg_addr == ST_A_ADDR) ack_vec = vec_a(wd16);
      if (reg_wr && reg_addr == ST_B_ADDR) ack_vec = vec_b(wd16);
   end

   assign busy = |pend_vec;

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_cell
      irq_evt_cell u_cell (
         .clk(clk), .srst(srst), .evt(evt_q[i]), .ack(ack_vec[i]),
         .busy(busy), .pend(pend_vec[i]), .held(held_vec[i]));
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         EN_A_ADDR: reg_rdata = word_a(en_vec);
         EN_B_ADDR: reg_rdata = word_b(en_vec);
         ST_A_ADDR: reg_rdata = word_a(pend_vec);
         ST_B_ADDR: reg_rdata = word_b(pend_vec);
         default:   reg_rdata = '0;
      endcase
   end

   assign irq_o       = busy;
   assign stat_pend_o = pend_vec;

   AST_REARM_AFTER_DIP: assert property (@(posedge clk) disable iff (srst)
      (busy && (pend_vec & ~ack_vec) == '0 && (held_vec | evt_q) != '0)
      |=> !irq_o ##1 irq_o);  // R6
   AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (srst)
      (pend_vec == '0 && held_vec == '0 && evt_q == '0) |=> !irq_o);  // R7
   AST_DISABLED_NOT_SEEN: assert property (@(posedge clk) disable iff (srst)
      (!busy && held_vec == '0 && (raw_evt & en_vec) == '0) |=> stat_pend_o == '0);  // R3
endmodule

// File: tb/irq_batch_ctrl_bench.sv
module irq_batch_ctrl_bench;
   logic        clk = 1'b0;
   logic        srst = 1'b1;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [15:0] reg_wdata = 16'h0000;
   logic [15:0] reg_rdata;
   logic [6:0]  evs = 7'b0;
   logic        irq_o;
   logic [4:0]  stat_pend_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit men[5];
   bit mpend[5];
   bit mheld[5];

   always #5 clk = ~clk;

   irq_batch_ctrl u_irq_batch_ctrl (
      .clk(clk), .srst(srst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_tx_dt_done(evs[0]), .ev_tx_hold(evs[1]), .ev_rx_dt_full(evs[2]),
      .ev_rx_hold(evs[3]), .ev_rx_blk_done(evs[4]), .ev_tx_underrun(evs[5]),
      .ev_rx_overrun(evs[6]), .irq_o(irq_o), .stat_pend_o(stat_pend_o));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] model_word(input logic [7:0] a);
      logic [15:0] w = '0;
      case (a)
         8'h58: begin w[11] = men[0]; w[8] = men[1]; w[2] = men[2]; end
         8'h59: begin w[5] = men[3]; w[2] = men[4]; end
         8'h5A: begin w[11] = mpend[0]; w[8] = mpend[1]; w[2] = mpend[2]; end
         8'h5B: begin w[5] = mpend[3]; w[2] = mpend[4]; end
         default: w = '0;
      endcase
      return w;
   endfunction

   // reference model, updated on every edge
   always @(posedge clk) begin
      bit q[5];
      bit a[5];
      bit any;
      q[0] = evs[0] | evs[1]; q[1] = evs[2] | evs[3]; q[2] = evs[4];
      q[3] = evs[5]; q[4] = evs[6];
      for (int i = 0; i < 5; i++) begin q[i] = q[i] & men[i]; a[i] = 1'b0; end
      if (reg_wr && reg_addr == 8'h5A) begin a[0] = reg_wdata[11]; a[1] = reg_wdata[8]; a[2] = reg_wdata[2]; end
      if (reg_wr && reg_addr == 8'h5B) begin a[3] = reg_wdata[5]; a[4] = reg_wdata[2]; end
      any = 1'b0;
      for (int i = 0; i < 5; i++) any |= mpend[i];
      if (srst) begin
         for (int i = 0; i < 5; i++) begin men[i] = 0; mpend[i] = 0; mheld[i] = 0; end
      end else begin
         for (int i = 0; i < 5; i++) begin
            if (!any) begin mpend[i] = mheld[i] | q[i]; mheld[i] = 0; end
            else begin mpend[i] = mpend[i] & ~a[i]; mheld[i] = mheld[i] | q[i]; end
         end
         if (reg_wr && reg_addr == 8'h58) begin men[0] = reg_wdata[11]; men[1] = reg_wdata[8]; men[2] = reg_wdata[2]; end
         if (reg_wr && reg_addr == 8'h59) begin men[3] = reg_wdata[5]; men[4] = reg_wdata[2]; end
      end
      #2;
      begin
         logic [4:0] ev;
         for (int i = 0; i < 5; i++) ev[i] = mpend[i];
         chk("R7 irq", {15'b0, irq_o}, {15'b0, |ev});
         chk("R9 status port", {11'b0, stat_pend_o}, {11'b0, ev});
      end
   end

   task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [6:0] e = 7'b0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d; evs = e;
      @(negedge clk);
      reg_wr = 1'b0; evs = 7'b0;
   endtask

   task automatic pulse(input logic [6:0] e);
      @(negedge clk); evs = e;
      @(negedge clk); evs = 7'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [15:0] exp);
      @(negedge clk); reg_addr = a; #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic rdm(input string tag, input logic [7:0] a);
      @(negedge clk); reg_addr = a; #1;
      chk(tag, reg_rdata, model_word(a));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      srst = 1'b0;
      rd("R2 reset enA", 8'h58, 16'h0000);
      rd("R2 reset stA", 8'h5A, 16'h0000);
      // R3: disabled events ignored
      pulse(7'h7F);
      @(negedge clk); chk("R3 no irq while disabled", {15'b0, irq_o}, 16'h0);
      wr(8'h58, 16'hFFFF);
      wr(8'h59, 16'hFFFF);
      rd("R1 enA mask", 8'h58, 16'h0904);
      rd("R1 enB mask", 8'h59, 16'h0024);
      rd("R12 unmapped", 8'h50, 16'h0000);
      rd("R12 unmapped", 8'h5C, 16'h0000);
      // R7 first batch
      pulse(7'b0010000);
      rd("R7 stA after blk", 8'h5A, 16'h0004);
      // R4 late event held
      pulse(7'b0100000);
      rd("R4 stB unchanged", 8'h5B, 16'h0000);
      rd("R4 stA unchanged", 8'h5A, 16'h0004);
      // R11 repeated pulses of held event
      pulse(7'b0100000); pulse(7'b0100000);
      // R5/R6 ack and re-arm
      wr(8'h5A, 16'h0004);
      chk("R6 dip", {15'b0, irq_o}, 16'h0);
      @(negedge clk); chk("R6 rearm", {15'b0, irq_o}, 16'h1);
      rd("R11 single held bit", 8'h5B, 16'h0020);
      // R10 event with ack
      wr(8'h5B, 16'h0020, 7'b1000000);
      chk("R10 dip", {15'b0, irq_o}, 16'h0);
      @(negedge clk);
      rd("R10 overrun kept", 8'h5B, 16'h0004);
      wr(8'h5B, 16'h0004);
      @(negedge clk);
      // R8 holds
      pulse(7'b0000010);
      rd("R8 tx hold", 8'h5A, 16'h0800);
      pulse(7'b0001000);
      wr(8'h5A, 16'h0800);
      @(negedge clk);
      rd("R8 rx hold", 8'h5A, 16'h0100);
      // R5 partial ack
      wr(8'h5A, 16'h0100);
      @(negedge clk);
      pulse(7'b1100101);
      rdm("R5 multi batch A", 8'h5A);
      wr(8'h5A, 16'h0800);
      rdm("R5 partial ack A", 8'h5A);
      chk("R5 irq still high", {15'b0, irq_o}, 16'h1);
      wr(8'h5A, 16'h0100);
      wr(8'h5B, 16'h0004);
      rdm("R5 after ack B", 8'h5B);
      wr(8'h5B, 16'h0020);
      @(negedge clk);
      // R3 disable B then pulse
      wr(8'h59, 16'h0000);
      pulse(7'b1100000);
      @(negedge clk); chk("R3 disabled B", {15'b0, irq_o}, 16'h0);
      // R2 mid-run reset
      pulse(7'b0000001);
      pulse(7'b0010000);
      @(negedge clk); srst = 1'b1;
      @(negedge clk); srst = 1'b0;
      rd("R2 reset enA again", 8'h58, 16'h0000);
      chk("R2 irq after reset", {15'b0, irq_o}, 16'h0);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule